// File: doc/BRIEF.md
# Two-Point Calibrated Voltage Converter

This block turns a raw 12-bit converter code and the number of the channel it came from into a voltage in millivolts. It fits a straight line through two calibration points and uses it to map the code to a voltage. The line depends on the channel. Channels that are already calibrated return that value as it stands. On every other channel the value then goes through a divider-ratio correction, with rounding to the nearest integer. Each channel's correction depends on a scale selector.

A request is a code, a channel and a scale. It is accepted by a valid/ready handshake. The block works through the request with one shared restoring divider that produces one quotient bit per cycle. It uses the divider once for the line and, where a correction applies, a second time for the ratio. When the result is ready, a single-cycle strobe marks it. The result word keeps its value until the next conversion finishes. The calibration points and ratios are fixed at build time.

The sequencer has five states:
- `ST_IDLE`: ready is high. A valid request goes to `ST_LINE_GO`.
- `ST_LINE_GO`: starts the line division and always goes to `ST_LINE_WAIT`.
- `ST_LINE_WAIT`: when the divider finishes, a calibrated channel returns to `ST_IDLE` and delivers its result. Any other channel goes to `ST_RATIO_GO`.
- `ST_RATIO_GO`: starts the ratio division and goes to `ST_RATIO_WAIT`.
- `ST_RATIO_WAIT`: returns to `ST_IDLE` and delivers its result when the divider finishes.

Top module: `cal_volt_conv`

## Requirements
- R1: After reset, `out_valid` is 0, `out_mv` is 0 and `in_ready` is 1.
- R2: A request is taken in a cycle where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the cycle in which `out_valid` rises; in that cycle `in_ready` is 1 again. Values on the inputs while `in_ready` is 0 have no effect on any result.
- R3: Channel 5 uses the high-range line, which passes through (code 2832, 3600 mV) and (code 3310, 4200 mV). Its line value is the result, with no correction.
- R4: Channel 1 uses the low-range line, which passes through (code 341, 100 mV) and (code 3413, 1000 mV). Its line value is the result, with no correction.
- R5: Every channel other than 1 and 5 uses the low-range line. It then returns (v·den + num/2)/num in integer arithmetic, where v is the line value and num/den is the channel's ratio.
- R6: A scale input that is not zero selects the ratio 400/1025 on channels 2, 3 and 4, and the ratio 100/125 on channels 7 and 8. A scale of zero selects 1/1 on all five of these channels.
- R7: Whatever the scale, channel 6 uses the ratio 375/9000 and channel 19 uses 1/3. Every channel not named in R3 to R6 uses 1/1.
- R8: The line value is (V0−V1)·(code−A1)/(A0−A1) + V1. The quotient in this formula truncates toward zero, so for example code 0 on channel 1 gives 1, not 0. A negative line value becomes 0, and the result is never negative.
- R9: `out_valid` is high for exactly one cycle per request. `out_mv` changes only in a cycle where `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A request is presented |
| in_ready | output | 1 | The block can take a request |
| in_code | input | CODE_W (12) | Raw converter code |
| in_chan | input | CHAN_W (5) | Channel number |
| in_scale | input | SCALE_W (3) | Scale selector; only whether it is zero matters |
| out_valid | output | 1 | One-cycle strobe when a new result is available |
| out_mv | output | 32 | Result in millivolts; holds until the next strobe |

## Verification
The assertions check the handshake and strobe rules on every cycle. The strobe never lasts two cycles. Ready drops after a request is taken, stays low while the divider runs, and is high in the strobe cycle. The result word never moves without the strobe and never carries a negative sign. Only the bench's scenarios can show that the arithmetic is right: line selection per channel, truncation toward zero below the lower calibration code, rounding in the ratio step, the scale-dependent ratio table, and inputs offered while busy being ignored. For those, each delivered value is compared against a behavioural integer model.

// File: rtl/cvc_pkg.sv
package cvc_pkg;
    localparam int CVC_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LINE_GO,
        ST_LINE_WAIT,
        ST_RATIO_GO,
        ST_RATIO_WAIT
    } cvc_state_t;

    typedef struct packed {
        logic signed [CVC_W-1:0] dv;   // V0 - V1
        logic        [CVC_W-1:0] da;   // A0 - A1
        logic signed [CVC_W-1:0] a1;
        logic signed [CVC_W-1:0] v1;
    } cvc_line_t;

    typedef struct packed {
        logic [CVC_W-1:0] num;
        logic [CVC_W-1:0] den;
    } cvc_ratio_t;
endpackage

// File: rtl/cvc_line_sel.sv
module cvc_line_sel
    import cvc_pkg::*;
#(
    parameter int CHAN_W   = 5,
    parameter int HI_CHAN  = 5,
    parameter int HI_V0    = 4200,
    parameter int HI_A0    = 3310,
    parameter int HI_V1    = 3600,
    parameter int HI_A1    = 2832,
    parameter int LO_V0    = 1000,
    parameter int LO_A0    = 3413,
    parameter int LO_V1    = 100,
    parameter int LO_A1    = 341
) (
    input  logic [CHAN_W-1:0] chan,
    output cvc_line_t         line
);
    always_comb begin
        if (int'(chan) == HI_CHAN) begin
            line.dv = CVC_W'(HI_V0 - HI_V1);
            line.da = CVC_W'(HI_A0 - HI_A1);
            line.a1 = CVC_W'(HI_A1);
            line.v1 = CVC_W'(HI_V1);
        end else begin
            line.dv = CVC_W'(LO_V0 - LO_V1);
            line.da = CVC_W'(LO_A0 - LO_A1);
            line.a1 = CVC_W'(LO_A1);
            line.v1 = CVC_W'(LO_V1);
        end
    end
endmodule

// File: rtl/cvc_ratio_sel.sv
module cvc_ratio_sel
    import cvc_pkg::*;
#(
    parameter int CHAN_W  = 5,
    parameter int SCALE_W = 3
) (
    input  logic [CHAN_W-1:0]  chan,
    input  logic [SCALE_W-1:0] scale,
    output cvc_ratio_t         ratio
);
    logic scaled;
    assign scaled = |scale;

    always_comb begin
        ratio.num = CVC_W'(1);
        ratio.den = CVC_W'(1);
        case (int'(chan))
            2, 3, 4: if (scaled) begin
                ratio.num = CVC_W'(400);
                ratio.den = CVC_W'(1025);
            end
            7, 8: if (scaled) begin
                ratio.num = CVC_W'(100);
                ratio.den = CVC_W'(125);
            end
            5: begin
                ratio.num = CVC_W'(7);
                ratio.den = CVC_W'(29);
            end
            6: begin
                ratio.num = CVC_W'(375);
                ratio.den = CVC_W'(9000);
            end
            19: begin
                ratio.num = CVC_W'(1);
                ratio.den = CVC_W'(3);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cvc_divider.sv
module cvc_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo,
    output logic         busy,
    output logic         done
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem;
    logic [W-1:0]     dsr;
    logic [CNT_W-1:0] cnt;
    logic [W:0]       part;
    logic [W:0]       trial;

    assign part  = {rem, quo[W-1]};
    assign trial = part - {1'b0, dsr};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            quo  <= '0;
            dsr  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem  <= '0;
                quo  <= dividend;
                dsr  <= divisor;
                cnt  <= CNT_W'(W);
                busy <= 1'b1;
            end else if (busy) begin
                if (!trial[W]) begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= part[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cal_volt_conv.sv
module cal_volt_conv
    import cvc_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int CHAN_W     = 5,
    parameter int SCALE_W    = 3,
    parameter int HI_CHAN    = 5,
    parameter int DIRECT_CHAN = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CODE_W-1:0]  in_code,
    input  logic [CHAN_W-1:0]  in_chan,
    input  logic [SCALE_W-1:0] in_scale,
    output logic               out_valid,
    output logic [CVC_W-1:0]   out_mv
);
    cvc_state_t st, st_nxt;

    logic [CODE_W-1:0]  code_r;
    logic [CHAN_W-1:0]  chan_r;
    logic [SCALE_W-1:0] scale_r;
    logic [CVC_W-1:0]   v_r;

    cvc_line_t  line;
    cvc_ratio_t ratio;

    logic signed [CVC_W-1:0] code_ext;
    logic signed [CVC_W-1:0] prod;
    logic                    prod_neg;
    logic        [CVC_W-1:0] prod_mag;
    logic signed [CVC_W-1:0] q_signed;
    logic signed [CVC_W-1:0] v_sum;
    logic        [CVC_W-1:0] v_clamp;
    logic                    direct;

    logic             div_start;
    logic [CVC_W-1:0] div_dividend;
    logic [CVC_W-1:0] div_divisor;
    logic [CVC_W-1:0] div_quo;
    logic             div_busy;
    logic             div_done;

    cvc_line_sel #(.CHAN_W(CHAN_W), .HI_CHAN(HI_CHAN)) u_line (
        .chan (chan_r),
        .line (line)
    );

    cvc_ratio_sel #(.CHAN_W(CHAN_W), .SCALE_W(SCALE_W)) u_ratio (
        .chan  (chan_r),
        .scale (scale_r),
        .ratio (ratio)
    );

    cvc_divider #(.W(CVC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .quo      (div_quo),
        .busy     (div_busy),
        .done     (div_done)
    );

    // line arithmetic: signed numerator, magnitude division, sign restored
    assign code_ext = $signed(CVC_W'(code_r));
    assign prod     = line.dv * (code_ext - line.a1);
    assign prod_neg = prod[CVC_W-1];
    assign prod_mag = prod_neg ? CVC_W'(-prod) : CVC_W'(prod);
    assign q_signed = prod_neg ? -$signed(div_quo) : $signed(div_quo);
    assign v_sum    = q_signed + line.v1;
    assign v_clamp  = v_sum[CVC_W-1] ? '0 : CVC_W'(v_sum);
    assign direct   = (int'(chan_r) == HI_CHAN) || (int'(chan_r) == DIRECT_CHAN);

    assign div_start    = (st == ST_LINE_GO) || (st == ST_RATIO_GO);
    assign div_dividend = (st == ST_LINE_GO) ? prod_mag
                                             : (v_r * ratio.den + (ratio.num >> 1));
    assign div_divisor  = (st == ST_LINE_GO) ? line.da : ratio.num;
    assign in_ready     = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:       if (in_valid) st_nxt = ST_LINE_GO;
            ST_LINE_GO:    st_nxt = ST_LINE_WAIT;
            ST_LINE_WAIT:  if (div_done) st_nxt = direct ? ST_IDLE : ST_RATIO_GO;
            ST_RATIO_GO:   st_nxt = ST_RATIO_WAIT;
            ST_RATIO_WAIT: if (div_done) st_nxt = ST_IDLE;
            default:       st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_r    <= '0;
            chan_r    <= '0;
            scale_r   <= '0;
            v_r       <= '0;
            out_mv    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (st)
                ST_IDLE: if (in_valid) begin
                    code_r  <= in_code;
                    chan_r  <= in_chan;
                    scale_r <= in_scale;
                end
                ST_LINE_WAIT: if (div_done) begin
                    v_r <= v_clamp;
                    if (direct) begin
                        out_mv    <= v_clamp;
                        out_valid <= 1'b1;
                    end
                end
                ST_RATIO_WAIT: if (div_done) begin
                    out_mv    <= div_quo;
                    out_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cvc_checker.sv
module cvc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic [31:0] out_mv,
    input logic        div_busy
);
    // R2
    take_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !in_ready);

    // R2
    strobe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_mv));

    // R8
    result_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_mv[31]);
endmodule

bind cal_volt_conv cvc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_mv    (out_mv),
    .div_busy  (div_busy)
);

// File: tb/cal_volt_conv_bench.sv
module cal_volt_conv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_code = '0;
    logic [4:0]  in_chan = '0;
    logic [2:0]  in_scale = '0;
    logic        out_valid;
    logic [31:0] out_mv;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    string tag_q[$];
    logic [31:0] last_mv = '0;
    logic prev_ov = 1'b0;
    bit finished = 0;

    always #4 clk = ~clk;

    cal_volt_conv u_cal_volt_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_code   (in_code),
        .in_chan   (in_chan),
        .in_scale  (in_scale),
        .out_valid (out_valid),
        .out_mv    (out_mv)
    );

    function automatic int ref_mv(int code, int chan, int scale);
        int v, n, d;
        if (chan == 5) v = (600 * (code - 2832)) / 478 + 3600;
        else           v = (900 * (code - 341)) / 3072 + 100;
        if (v < 0) v = 0;
        if (chan == 5 || chan == 1) return v;
        n = 1; d = 1;
        if ((chan >= 2 && chan <= 4) && scale != 0) begin n = 400; d = 1025; end
        if ((chan == 7 || chan == 8) && scale != 0) begin n = 100; d = 125; end
        if (chan == 6)  begin n = 375; d = 9000; end
        if (chan == 19) begin n = 1;   d = 3;    end
        return (v * d + n / 2) / n;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic send(int code, int chan, int scale, string tag);
        @(posedge clk); #1;
        while (!in_ready) begin @(posedge clk); #1; end
        in_valid = 1'b1;
        in_code  = 12'(code);
        in_chan  = 5'(chan);
        in_scale = 3'(scale);
        @(posedge clk);
        exp_q.push_back(ref_mv(code, chan, scale));
        tag_q.push_back(tag);
        #1 in_valid = 1'b0;
    endtask

    // per-cycle comparison against the queued model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected strobe", 1, 0);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_mv == 32'(e), t, int'(out_mv), e);
                end
                check(in_ready == 1'b1, "R2 ready at strobe", int'(in_ready), 1);
                check(!prev_ov, "R9 strobe width", 1, 0);
                last_mv = out_mv;
            end else begin
                check(out_mv == last_mv, "R9 hold", int'(out_mv), int'(last_mv));
                check(in_ready == (exp_q.size() == 0), "R2 ready while busy",
                      int'(in_ready), int'(exp_q.size() == 0));
            end
            prev_ov = out_valid;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_mv == 32'd0, "R1 result", int'(out_mv), 0);
        check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);

        // R3 high-range line on its calibration points and extremes
        send(3310, 5, 0, "R3 ch5 upper point");
        send(2832, 5, 3, "R3 ch5 lower point");
        send(0,    5, 0, "R3 ch5 code 0");
        send(4095, 5, 0, "R3 ch5 code max");
        // R4 low-range line, direct
        send(3413, 1, 0, "R4 ch1 upper point");
        send(341,  1, 5, "R4 ch1 lower point");
        send(4095, 1, 0, "R4 ch1 code max");
        // R8 truncation toward zero below A1: code 0 gives 1
        send(0,    1, 0, "R8 ch1 code 0");
        send(100,  1, 0, "R8 ch1 code 100");
        // R5 plain channels 1/1
        send(2000, 0, 0, "R5 ch0");
        send(1234, 12, 7, "R5 ch12");
        // R6 scale-dependent ratios
        send(3000, 2, 1, "R6 ch2 scaled");
        send(3000, 3, 0, "R6 ch3 unscaled");
        send(4095, 4, 2, "R6 ch4 scaled");
        send(2500, 7, 4, "R6 ch7 scaled");
        send(2500, 8, 0, "R6 ch8 unscaled");
        // R7 fixed ratios
        send(3413, 6, 0, "R7 ch6");
        send(777,  6, 1, "R7 ch6 scaled");
        send(2222, 19, 0, "R7 ch19");
        send(2222, 31, 3, "R7 ch31");

        // R2 inputs while busy are ignored
        send(3100, 6, 0, "R2 ignored busy input");
        for (int k = 0; k < 6; k++) begin
            in_valid = 1'b1;
            in_code  = 12'hFFF;
            in_chan  = 5'd19;
            in_scale = 3'd1;
            @(posedge clk); #1;
        end
        in_valid = 1'b0;

        // sweep across codes for several channels
        for (int c = 0; c < 4096; c += 517) begin
            send(c, 5, 0, "R3 sweep");
            send(c, 2, 1, "R5 sweep ch2");
            send(c, 19, 0, "R7 sweep ch19");
        end

        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule